// File: doc/BRIEF.md
# Configuration Access Lane Steering Unit

This unit sits between a processor-side register access port and a root port's configuration request port. Software first programs a target header (bus number, device/function number, an optional byte-enable override and its force flag). It then reads or writes the configuration data window. The unit turns each window access of 1, 2 or 4 bytes into exactly one 32-bit downstream request. That request carries byte enables for the addressed lanes and write data already shifted onto those lanes. Read data comes back as the whole 32-bit word, and the requester picks out the bytes it needs.

Each window access uses up the header. An access that arrives without a fresh header write, that straddles a 4-byte boundary, or that uses the reserved size code is refused with an error response, and no downstream request is made. The unit handles one access at a time.

A four-state machine controls the flow:
- `ST_IDLE` accepts an access. It goes to `ST_ISSUE` for a legal window access. It goes to `ST_RESP` for a header access or any refused access.
- `ST_ISSUE` holds the downstream request until it is accepted, then goes to `ST_WAIT`.
- `ST_WAIT` waits for the completion, then goes to `ST_RESP`.
- `ST_RESP` presents the one-cycle response and returns to `ST_IDLE`.

Top module: `cfg_steer_unit`

## Requirements
- R1: The header register sits at address 0x000 and must be accessed with size code 2 (4 bytes). Its fields are: device/function in bits 7:0, bus number in bits 15:8, byte-enable override in bits 19:16, and the force flag in bit 20. A read returns these bits zero-extended. A header access with any other size gets an error response and leaves the register unchanged. After reset the register reads as zero.
- R2: A window access is legal only if the header was written after the previous window access, or after reset. Each window access, whether legal or refused, uses up the header. An access without a fresh header gets an error response and issues no request.
- R3: When the force flag is clear, the downstream byte enables are a mask with one bit per accessed byte, shifted left by address bits 1:0. Size code 0 means 1 byte, code 1 means 2 bytes, code 2 means 4 bytes.
- R4: When the force flag is set, the downstream byte enables are the header's override field, whatever the size and offset.
- R5: For a write, the data is cut to the access size and shifted left by 8 times address bits 1:0. A 4-byte write is passed through unchanged. Read requests carry zero data, and write responses return zero data.
- R6: A legal window access issues exactly one request. The request carries the write flag, the header's bus and device/function fields, and the dword address taken from address bits 11:2.
- R7: An access with size code 3, or whose offset plus byte count is more than 4, gets an error response and issues no request.
- R8: A read returns the completion's full 32-bit word unshifted, with no error.
- R9: While a request is waiting for the downstream ready, every request field stays stable.
- R10: An address that is neither the header address nor inside the 4 KB window starting at 0x1000 gets an error response and issues no request.
- R11: The access port is ready only when the unit is idle. The response valid is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Unit idle and able to take an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (13) | Byte address of the access |
| req_size | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = reserved |
| req_wdata | input | DATA_W (32) | Write data, right-aligned |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Access refused |
| rsp_rdata | output | DATA_W (32) | Read data |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream accepts the request |
| dn_req_write | output | 1 | Request is a write |
| dn_req_bus | output | 8 | Target bus number |
| dn_req_devfn | output | 8 | Target device/function |
| dn_req_dw_addr | output | 10 | Configuration dword address |
| dn_req_be | output | 4 | Byte enables |
| dn_req_wdata | output | DATA_W (32) | Lane-aligned write data |
| dn_rsp_valid | input | 1 | Completion strobe |
| dn_rsp_rdata | input | DATA_W (32) | Completion data |

## Verification
The bench targets these corner cases:
- Top-lane offsets for byte and halfword accesses. A wrong shift amount would put data or enables on the wrong lanes.
- Halfword and word accesses that cross a dword boundary. A unit that missed the check would issue a request with truncated enables instead of refusing it.
- The force flag set with an override that disagrees with the computed mask. A unit that ignored the flag would still send the computed mask.
- Write data with junk above the access size. A unit that did not mask it would leak that junk onto unaddressed lanes.
- Back-to-back window accesses on one header. A unit that did not consume the header would issue the second request instead of refusing it.
- A request held through several downstream stall cycles. A unit whose fields changed during the stall would fail the stability check.
- Malformed header writes and out-of-range addresses. These must be refused without changing the stored header.

// File: rtl/cfg_steer_pkg.sv
package cfg_steer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } cfg_state_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } cfg_size_e;

    // Header layout: bit 20 force, 19:16 override enables, 15:8 bus, 7:0 devfn
    typedef struct packed {
        logic       force_be;
        logic [3:0] be;
        logic [7:0] bus;
        logic [7:0] devfn;
    } cfg_hdr_t;

    localparam int HDR_W = $bits(cfg_hdr_t);

endpackage

// File: rtl/cfg_lane_calc.sv
module cfg_lane_calc #(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic [1:0]        size_code,
    input  logic [OFF_W-1:0]  offset,
    input  logic              is_write,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic              force_be,
    input  logic [LANES-1:0]  override_be,
    output logic [LANES-1:0]  be_out,
    output logic [DATA_W-1:0] wdata_out,
    output logic              bad
);

    logic [OFF_W:0]      nbytes;
    logic [OFF_W+1:0]    span_end;
    logic [LANES-1:0]    size_mask;
    logic [DATA_W-1:0]   data_mask;
    logic                size_bad;
    logic                crosses;

    assign size_bad = (int'(size_code) > OFF_W);
    assign nbytes   = size_bad ? '0 : (OFF_W+1)'(1 << size_code);
    assign span_end = {2'b00, offset} + {1'b0, nbytes};
    assign crosses  = (span_end > (OFF_W+2)'(LANES));
    assign bad      = size_bad || crosses;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign size_mask[i]          = (i < int'(nbytes));
        assign data_mask[8*i +: 8]   = {8{size_mask[i]}};
    end

    always_comb begin
        if (force_be) begin
            be_out = override_be;
        end else begin
            be_out = size_mask << offset;
        end
        if (is_write) begin
            wdata_out = (wdata_in & data_mask) << (8 * int'(offset));
        end else begin
            wdata_out = '0;
        end
    end

endmodule

// File: rtl/cfg_hdr_reg.sv
module cfg_hdr_reg
    import cfg_steer_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  cfg_hdr_t wr_hdr,
    input  logic     consume,
    output cfg_hdr_t hdr,
    output logic     armed
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr   <= '0;
            armed <= 1'b0;
        end else begin
            if (wr_en) begin
                hdr   <= wr_hdr;
                armed <= 1'b1;
            end else if (consume) begin
                armed <= 1'b0;
            end
        end
    end

    // R2
    hdr_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && !wr_en) |=> !armed);

endmodule

// File: rtl/cfg_access_fsm.sv
module cfg_access_fsm
    import cfg_steer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_issue,
    input  logic       start_direct,
    input  logic       dn_req_ready,
    input  logic       dn_rsp_valid,
    output cfg_state_e state,
    output logic       req_ready,
    output logic       dn_req_valid,
    output logic       rsp_valid
);

    cfg_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start_issue) begin
                    state_nx = ST_ISSUE;
                end else if (start_direct) begin
                    state_nx = ST_RESP;
                end
            end
            ST_ISSUE: if (dn_req_ready) state_nx = ST_WAIT;
            ST_WAIT:  if (dn_rsp_valid) state_nx = ST_RESP;
            ST_RESP:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready    = (state == ST_IDLE);
        dn_req_valid = (state == ST_ISSUE);
        rsp_valid    = (state == ST_RESP);
    end

    // R11
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R11
    idle_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && (rsp_valid || dn_req_valid)));

endmodule

// File: rtl/cfg_steer_unit.sv
module cfg_steer_unit
    import cfg_steer_pkg::*;
#(
    parameter int              ADDR_W   = 13,
    parameter int              WIN_AW   = 12,
    parameter logic [ADDR_W-1:0] WIN_BASE = 13'h1000,
    parameter logic [ADDR_W-1:0] HDR_ADDR = 13'h0000,
    parameter int              DATA_W   = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES),
    localparam int DW_AW = WIN_AW - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              dn_req_valid,
    input  logic              dn_req_ready,
    output logic              dn_req_write,
    output logic [7:0]        dn_req_bus,
    output logic [7:0]        dn_req_devfn,
    output logic [DW_AW-1:0]  dn_req_dw_addr,
    output logic [LANES-1:0]  dn_req_be,
    output logic [DATA_W-1:0] dn_req_wdata,
    input  logic              dn_rsp_valid,
    input  logic [DATA_W-1:0] dn_rsp_rdata
);

    cfg_state_e        state;
    cfg_hdr_t          hdr_q;
    logic              armed;
    logic              accept;
    logic              is_hdr;
    logic              is_win;
    logic              hdr_ok;
    logic              hdr_wr;
    logic              win_take;
    logic              win_go;
    logic              go_direct;
    logic [LANES-1:0]  calc_be;
    logic [DATA_W-1:0] calc_wd;
    logic              calc_bad;
    logic              lat_write;
    logic [LANES-1:0]  lat_be;
    logic [DATA_W-1:0] lat_wd;
    logic [DW_AW-1:0]  lat_dw;
    logic [DATA_W-1:0] rdata_q;
    logic              err_q;

    assign accept    = req_valid && req_ready;
    assign is_hdr    = (req_addr == HDR_ADDR);
    assign is_win    = (req_addr[ADDR_W-1:WIN_AW] == WIN_BASE[ADDR_W-1:WIN_AW]);
    assign hdr_ok    = is_hdr && (req_size == SZ_WORD);
    assign hdr_wr    = accept && hdr_ok && req_write;
    assign win_take  = accept && is_win;
    assign win_go    = win_take && armed && !calc_bad;
    assign go_direct = accept && !win_go;

    cfg_lane_calc #(.DATA_W(DATA_W)) u_lane (
        .size_code   (req_size),
        .offset      (req_addr[OFF_W-1:0]),
        .is_write    (req_write),
        .wdata_in    (req_wdata),
        .force_be    (hdr_q.force_be),
        .override_be (hdr_q.be),
        .be_out      (calc_be),
        .wdata_out   (calc_wd),
        .bad         (calc_bad)
    );

    cfg_hdr_reg u_hdr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (hdr_wr),
        .wr_hdr  (req_wdata[HDR_W-1:0]),
        .consume (win_take),
        .hdr     (hdr_q),
        .armed   (armed)
    );

    cfg_access_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_issue  (win_go),
        .start_direct (go_direct),
        .dn_req_ready (dn_req_ready),
        .dn_rsp_valid (dn_rsp_valid),
        .state        (state),
        .req_ready    (req_ready),
        .dn_req_valid (dn_req_valid),
        .rsp_valid    (rsp_valid)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_write <= 1'b0;
            lat_be    <= '0;
            lat_wd    <= '0;
            lat_dw    <= '0;
        end else if (win_go) begin
            lat_write <= req_write;
            lat_be    <= calc_be;
            lat_wd    <= calc_wd;
            lat_dw    <= req_addr[WIN_AW-1:OFF_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else if (go_direct) begin
            err_q   <= !hdr_ok;
            rdata_q <= (hdr_ok && !req_write) ? DATA_W'(hdr_q) : '0;
        end else if (state == ST_WAIT && dn_rsp_valid) begin
            err_q   <= 1'b0;
            rdata_q <= lat_write ? '0 : dn_rsp_rdata;
        end
    end

    assign rsp_err        = err_q;
    assign rsp_rdata      = rdata_q;
    assign dn_req_write   = lat_write;
    assign dn_req_bus     = hdr_q.bus;
    assign dn_req_devfn   = hdr_q.devfn;
    assign dn_req_dw_addr = lat_dw;
    assign dn_req_be      = lat_be;
    assign dn_req_wdata   = lat_wd;

    // R9
    req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req_valid && !dn_req_ready) |=> (dn_req_valid && $stable(dn_req_be)
            && $stable(dn_req_wdata) && $stable(dn_req_dw_addr)
            && $stable(dn_req_write) && $stable(dn_req_bus)));

    // R4
    force_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req_valid && hdr_q.force_be) |-> (dn_req_be == hdr_q.be));

    // R5
    read_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req_valid && !dn_req_write) |-> (dn_req_wdata == '0));

    // R7
    refuse_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_take && calc_bad) |=> (rsp_valid && rsp_err));

endmodule

// File: tb/cfg_steer_unit_tb_top.sv
module cfg_steer_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 13;

    typedef struct packed {
        logic [20:0] hdr;
        logic        wr;
        logic [12:0] addr;
        logic [1:0]  size;
        logic [31:0] wdata;
        logic        e_err;
        logic [3:0]  e_be;
        logic [31:0] e_wd;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{21'h001234, 1'b1, 13'h1001, 2'd0, 32'h000000AB, 1'b0, 4'h2, 32'h0000AB00},
        '{21'h1C1234, 1'b1, 13'h1006, 2'd1, 32'h0000BEEF, 1'b0, 4'hC, 32'hBEEF0000},
        '{21'h00AB05, 1'b1, 13'h1008, 2'd2, 32'h11223344, 1'b0, 4'hF, 32'h11223344},
        '{21'h000102, 1'b1, 13'h1003, 2'd0, 32'h0000005A, 1'b0, 4'h8, 32'h5A000000},
        '{21'h000102, 1'b1, 13'h1003, 2'd1, 32'h00001111, 1'b1, 4'h0, 32'h00000000},
        '{21'h000102, 1'b0, 13'h1002, 2'd2, 32'h00000000, 1'b1, 4'h0, 32'h00000000},
        '{21'h000102, 1'b1, 13'h1000, 2'd3, 32'h00000001, 1'b1, 4'h0, 32'h00000000},
        '{21'h00FF07, 1'b0, 13'h1002, 2'd1, 32'h00000000, 1'b0, 4'hC, 32'h00000000},
        '{21'h131234, 1'b1, 13'h1003, 2'd0, 32'h00000077, 1'b0, 4'h3, 32'h77000000},
        '{21'h000000, 1'b1, 13'h1FFC, 2'd1, 32'hFFFF1234, 1'b0, 4'h3, 32'h00001234},
        '{21'h000000, 1'b0, 13'h1FFD, 2'd0, 32'h00000000, 1'b0, 4'h2, 32'h00000000},
        '{21'h1F0000, 1'b0, 13'h1001, 2'd1, 32'h00000000, 1'b0, 4'hF, 32'h00000000},
        '{21'h000000, 1'b1, 13'h1101, 2'd1, 32'h0000CAFE, 1'b0, 4'h6, 32'h00CAFE00}
    };

    logic        clk;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic        req_write;
    logic [12:0] req_addr;
    logic [1:0]  req_size;
    logic [31:0] req_wdata;
    logic        rsp_valid;
    logic        rsp_err;
    logic [31:0] rsp_rdata;
    logic        dn_req_valid;
    logic        dn_req_ready;
    logic        dn_req_write;
    logic [7:0]  dn_req_bus;
    logic [7:0]  dn_req_devfn;
    logic [9:0]  dn_req_dw_addr;
    logic [3:0]  dn_req_be;
    logic [31:0] dn_req_wdata;
    logic        dn_rsp_valid;
    logic [31:0] dn_rsp_rdata;

    int   n_chk;
    int   n_fail;
    logic finished;

    logic        cap_valid;
    logic        cap_write;
    logic [3:0]  cap_be;
    logic [31:0] cap_wd;
    logic [7:0]  cap_bus;
    logic [7:0]  cap_devfn;
    logic [9:0]  cap_dw;
    logic        stable_bad;
    logic        got_rsp;
    logic        res_err;
    logic [31:0] res_rdata;

    cfg_steer_unit dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_write      (req_write),
        .req_addr       (req_addr),
        .req_size       (req_size),
        .req_wdata      (req_wdata),
        .rsp_valid      (rsp_valid),
        .rsp_err        (rsp_err),
        .rsp_rdata      (rsp_rdata),
        .dn_req_valid   (dn_req_valid),
        .dn_req_ready   (dn_req_ready),
        .dn_req_write   (dn_req_write),
        .dn_req_bus     (dn_req_bus),
        .dn_req_devfn   (dn_req_devfn),
        .dn_req_dw_addr (dn_req_dw_addr),
        .dn_req_be      (dn_req_be),
        .dn_req_wdata   (dn_req_wdata),
        .dn_rsp_valid   (dn_rsp_valid),
        .dn_rsp_rdata   (dn_rsp_rdata)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [12:0] addr, input logic [1:0] sz,
                          input logic [31:0] wd, input int stall);
        int  st;
        logic pend;
        st = stall;
        pend = 1'b0;
        cap_valid = 1'b0;
        stable_bad = 1'b0;
        got_rsp = 1'b0;
        res_err = 1'b0;
        res_rdata = '0;
        dn_req_ready = (stall == 0);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = addr;
        req_size  = sz;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (rsp_valid) begin
                got_rsp = 1'b1;
                res_err = rsp_err;
                res_rdata = rsp_rdata;
                break;
            end
            dn_rsp_valid = 1'b0;
            if (pend) begin
                dn_rsp_valid = 1'b1;
                dn_rsp_rdata = 32'hC0DE0000 | {19'b0, addr};
                pend = 1'b0;
            end else if (dn_req_valid) begin
                if (cap_valid && (dn_req_be !== cap_be || dn_req_wdata !== cap_wd ||
                    dn_req_dw_addr !== cap_dw || dn_req_write !== cap_write))
                    stable_bad = 1'b1;
                cap_valid = 1'b1;
                cap_write = dn_req_write;
                cap_be    = dn_req_be;
                cap_wd    = dn_req_wdata;
                cap_bus   = dn_req_bus;
                cap_devfn = dn_req_devfn;
                cap_dw    = dn_req_dw_addr;
                if (st > 0) begin
                    st--;
                    dn_req_ready = 1'b0;
                end else begin
                    dn_req_ready = 1'b1;
                    pend = 1'b1;
                end
            end
            @(negedge clk);
        end
        dn_rsp_valid = 1'b0;
        dn_req_ready = 1'b1;
        chk("R11 response seen", 32'(got_rsp), 32'd1);
    endtask

    task automatic hdr_write(input logic [20:0] h);
        access(1'b1, 13'h0000, 2'd2, {11'b0, h}, 0);
        chk("R1 header write ok", 32'(res_err), 32'd0);
    endtask

    initial begin
        finished = 1'b0;
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        n_chk = 0;
        n_fail = 0;
        rst_n = 1'b0;
        req_valid = 1'b0;
        req_write = 1'b0;
        req_addr = '0;
        req_size = '0;
        req_wdata = '0;
        dn_req_ready = 1'b1;
        dn_rsp_valid = 1'b0;
        dn_rsp_rdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R11, R1)
        chk("R11 ready after reset", 32'(req_ready), 32'd1);
        chk("R11 no rsp after reset", 32'(rsp_valid), 32'd0);
        chk("R6 no request after reset", 32'(dn_req_valid), 32'd0);

        // R2: window access with no header written since reset
        access(1'b1, 13'h1000, 2'd2, 32'h1, 0);
        chk("R2 unarmed err", 32'(res_err), 32'd1);
        chk("R2 unarmed no request", 32'(cap_valid), 32'd0);

        // R1: header reads zero after reset
        access(1'b0, 13'h0000, 2'd2, 32'h0, 0);
        chk("R1 reset header", res_rdata, 32'h0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            hdr_write(VECS[v].hdr);
            access(VECS[v].wr, VECS[v].addr, VECS[v].size, VECS[v].wdata, 0);
            chk("R7 err flag", 32'(res_err), 32'(VECS[v].e_err));
            chk("R6 request issued", 32'(cap_valid), 32'(!VECS[v].e_err));
            if (!VECS[v].e_err) begin
                if (VECS[v].hdr[20])
                    chk("R4 forced enables", 32'(cap_be), 32'(VECS[v].e_be));
                else
                    chk("R3 computed enables", 32'(cap_be), 32'(VECS[v].e_be));
                chk("R5 lane data", cap_wd, VECS[v].e_wd);
                chk("R6 write flag", 32'(cap_write), 32'(VECS[v].wr));
                chk("R6 bus", 32'(cap_bus), 32'(VECS[v].hdr[15:8]));
                chk("R6 devfn", 32'(cap_devfn), 32'(VECS[v].hdr[7:0]));
                chk("R6 dword addr", 32'(cap_dw), 32'(VECS[v].addr[11:2]));
                if (VECS[v].wr)
                    chk("R5 write rsp data", res_rdata, 32'h0);
                else
                    chk("R8 read data", res_rdata, 32'hC0DE0000 | {19'b0, VECS[v].addr});
            end
        end

        // R2: header consumed by one access
        hdr_write(21'h000505);
        access(1'b0, 13'h1010, 2'd2, 32'h0, 0);
        chk("R2 first access ok", 32'(res_err), 32'd0);
        access(1'b0, 13'h1010, 2'd2, 32'h0, 0);
        chk("R2 second access err", 32'(res_err), 32'd1);
        chk("R2 second no request", 32'(cap_valid), 32'd0);

        // R2: a refused access also consumes the header
        hdr_write(21'h000505);
        access(1'b1, 13'h1002, 2'd2, 32'h0, 0);
        chk("R7 crossing refused", 32'(res_err), 32'd1);
        access(1'b1, 13'h1004, 2'd2, 32'h0, 0);
        chk("R2 refused consumes", 32'(res_err), 32'd1);

        // R1: header readback and malformed header write
        hdr_write(21'h15A3C7);
        access(1'b1, 13'h0000, 2'd0, 32'h001FFFFF, 0);
        chk("R1 narrow header write err", 32'(res_err), 32'd1);
        access(1'b0, 13'h0000, 2'd2, 32'h0, 0);
        chk("R1 header readback", res_rdata, 32'h0015A3C7);

        // R10: addresses outside header and window
        hdr_write(21'h000001);
        access(1'b0, 13'h0800, 2'd2, 32'h0, 0);
        chk("R10 hole err", 32'(res_err), 32'd1);
        chk("R10 hole no request", 32'(cap_valid), 32'd0);
        access(1'b0, 13'h0004, 2'd2, 32'h0, 0);
        chk("R10 near-header err", 32'(res_err), 32'd1);

        // R9: downstream stall keeps request stable
        hdr_write(21'h004321);
        access(1'b1, 13'h1022, 2'd1, 32'h0000A5A5, 4);
        chk("R9 stable during stall", 32'(stable_bad), 32'd0);
        chk("R9 data after stall", cap_wd, 32'hA5A50000);
        chk("R9 enables after stall", 32'(cap_be), 32'hC);

        // R11: response is one cycle, then idle
        @(negedge clk);
        chk("R11 rsp pulse ends", 32'(rsp_valid), 32'd0);
        chk("R11 ready again", 32'(req_ready), 32'd1);

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule